// File: doc/BRIEF.md
# Interrupt Domain Register Decoder

This block is the 32-bit memory-mapped register front end of an interrupt domain. It takes one register access per cycle, decodes the word offset and answers one cycle later with read data or an error flag. Writes to the pending and enable bit arrays become per-source set or clear strobes. Writes to the by-number registers become a single strobe. Writes to the per-source configuration and target arrays become write enables with a source index. The storage of per-source state and the formatting of messages sit in neighbouring blocks. This block holds only the domain interrupt-enable bit and the generate-message word.

Reads of the bit arrays collect per-source bits into 32-bit words. Bit i of word w is source 32*w + i. Source 0 does not exist and always reads as zero. After every accepted write the block pulses a rescan request so that the delivery scanner re-evaluates all sources.

Top module: `irqd_regdec`

## Requirements
- R1: An access whose offset has either of its two low bits set, or whose size input is not 4, gets rsp_err_o = 1 and changes nothing: no strobe, no write enable, no message request, no rescan, and the domain enable is kept.
- R2: An access to an offset outside every decoded range gets rsp_err_o = 1. The decoded ranges are: 0x0000; the source configuration array; the four bit arrays at 0x1C00, 0x1D00, 0x1E00 and 0x1F00; the by-number words at 0x1CDC, 0x1DDC, 0x1EDC, 0x1FDC, 0x2000 and 0x2004; 0x3000; and the target array.
- R3: A read of offset 0x0000 returns 0x80000000 | (1 << 2) | (ie << 8). A write to it stores only bit 8 as the domain enable, which is driven on dom_ie_o.
- R4: The configuration array starts at 0x0004 and the target array starts at 0x3004. Each has NUM_SRC words, and word k selects source k+1. A read returns cfg_rdata_i or tgt_rdata_i for the source on rd_src_o. A write pulses cfg_we_o or tgt_we_o with wr_src_o and wr_data_o. One word past the end of either array is an error.
- R5: A write to the set-pending array (0x1C00) or the set-enable array (0x1E00) pulses a set strobe for source 32*w+i for each 1 in bit i of word w. The clear-pending array (0x1D00) and the clear-enable array (0x1F00) do the same with clear strobes. Zero bits do nothing, and source 0 is never strobed.
- R6: A read of the set-pending array returns pending bits from pend_i. A read of the clear-pending array returns input levels from level_i. A read of the set-enable array returns enable bits from en_i. Bit 0 of word 0 and all bits above NUM_SRC read as 0.
- R7: Reads of the clear-enable array and of every by-number register return 0.
- R8: A write to a by-number register (0x1CDC set-pending, 0x1DDC clear-pending, 0x1EDC set-enable, 0x1FDC clear-enable, 0x2000 set-pending) with value n pulses exactly one strobe, for source n, when 1 <= n <= NUM_SRC. Any other n is still accepted without error but pulses no strobe.
- R9: A write to 0x2004 byte-reverses the 32-bit value and then acts as a set-pending by number.
- R10: Each bit array has ceil((NUM_SRC+1)/32) words. Offsets past the last word are errors.
- R11: A write to 0x3000 stores the value with bits 17:12 cleared, drives the stored word on genmsi_o and pulses msi_req_o. A read of 0x3000 returns the stored word.
- R12: rescan_o pulses for one cycle, one cycle after the strobes of each accepted write. It does not pulse for reads or rejected accesses.
- R13: rsp_valid_o follows each request by one cycle, and strobes and write enables appear in that same cycle. rsp_rdata_o is 0 for writes and for errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Byte offset in the register window |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_err_o | output | 1 | Access rejected |
| rsp_rdata_o | output | 32 | Read data |
| rd_src_o | output | IW | Source selected by the current configuration or target read |
| cfg_rdata_i | input | 32 | Configuration word of source rd_src_o |
| tgt_rdata_i | input | 32 | Target word of source rd_src_o |
| pend_i | input | NUM_SRC+1 | Pending bits per source |
| level_i | input | NUM_SRC+1 | Recorded input level per source |
| en_i | input | NUM_SRC+1 | Enable bits per source |
| set_pend_o | output | NUM_SRC+1 | Set-pending strobes |
| clr_pend_o | output | NUM_SRC+1 | Clear-pending strobes |
| set_en_o | output | NUM_SRC+1 | Set-enable strobes |
| clr_en_o | output | NUM_SRC+1 | Clear-enable strobes |
| cfg_we_o | output | 1 | Configuration write enable |
| tgt_we_o | output | 1 | Target write enable |
| wr_src_o | output | IW | Source of the configuration or target write |
| wr_data_o | output | 32 | Data of the configuration or target write |
| dom_ie_o | output | 1 | Domain interrupt enable |
| msi_req_o | output | 1 | Generate-message request pulse |
| genmsi_o | output | 32 | Stored generate-message word |
| rescan_o | output | 1 | Rescan request to the delivery scanner |

## Verification
The rescan pulse of one write can land in the same cycle as the strobes of the next write. The bench provokes this by issuing two set-pending-by-number writes on consecutive cycles. It judges the result by sampling that cycle: the second source's strobe must be present alone, and rescan_o must be high. The error path and the rescan path can also meet. A rejected write that directly follows an accepted one must leave its own cycle free of strobes while the earlier write's rescan still goes out.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_DOMCFG, OP_SRCCFG, OP_SETIP, OP_SETIPNUM, OP_CLRIP, OP_CLRIPNUM,
    OP_SETIE, OP_SETIENUM, OP_CLRIE, OP_CLRIENUM, OP_NUM_LE, OP_NUM_BE,
    OP_GENMSI, OP_TARGET
  } reg_op_e;

  localparam logic [31:0] OFF_DOMCFG   = 32'h0000;
  localparam logic [31:0] OFF_SRCCFG   = 32'h0004;
  localparam logic [31:0] OFF_SETIP    = 32'h1C00;
  localparam logic [31:0] OFF_SETIPNUM = 32'h1CDC;
  localparam logic [31:0] OFF_CLRIP    = 32'h1D00;
  localparam logic [31:0] OFF_CLRIPNUM = 32'h1DDC;
  localparam logic [31:0] OFF_SETIE    = 32'h1E00;
  localparam logic [31:0] OFF_SETIENUM = 32'h1EDC;
  localparam logic [31:0] OFF_CLRIE    = 32'h1F00;
  localparam logic [31:0] OFF_CLRIENUM = 32'h1FDC;
  localparam logic [31:0] OFF_NUM_LE   = 32'h2000;
  localparam logic [31:0] OFF_NUM_BE   = 32'h2004;
  localparam logic [31:0] OFF_GENMSI   = 32'h3000;
  localparam logic [31:0] OFF_TARGET   = 32'h3004;

endpackage

// File: rtl/irqd_addr_decode.sv
module irqd_addr_decode
  import irqd_pkg::*;
#(
  parameter int AW      = 16,
  parameter int NUM_SRC = 40,
  parameter int NWORDS  = 2,
  parameter int IW      = 6,
  parameter int WW      = 1
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    size_i,
  output reg_op_e       op_o,
  output logic [IW-1:0] src_o,
  output logic [WW-1:0] word_o,
  output logic          err_o
);

  localparam logic [31:0] ARR_SPAN = 32'(NUM_SRC * 4);
  localparam logic [31:0] BIT_SPAN = 32'(NWORDS * 4);

  logic [31:0] off;
  assign off = 32'(addr_i);

  function automatic logic in_bits(input logic [31:0] o, input logic [31:0] base);
    return (o >= base) && (o < base + BIT_SPAN);
  endfunction

  function automatic logic in_arr(input logic [31:0] o, input logic [31:0] base);
    return (o >= base) && (o < base + ARR_SPAN);
  endfunction

  always_comb begin
    op_o   = OP_NONE;
    src_o  = '0;
    word_o = '0;
    if (off == OFF_DOMCFG) op_o = OP_DOMCFG;
    else if (in_arr(off, OFF_SRCCFG)) begin
      op_o  = OP_SRCCFG;
      src_o = IW'(((off - OFF_SRCCFG) >> 2) + 32'd1);
    end else if (in_bits(off, OFF_SETIP)) begin
      op_o   = OP_SETIP;
      word_o = WW'((off - OFF_SETIP) >> 2);
    end else if (off == OFF_SETIPNUM) op_o = OP_SETIPNUM;
    else if (in_bits(off, OFF_CLRIP)) begin
      op_o   = OP_CLRIP;
      word_o = WW'((off - OFF_CLRIP) >> 2);
    end else if (off == OFF_CLRIPNUM) op_o = OP_CLRIPNUM;
    else if (in_bits(off, OFF_SETIE)) begin
      op_o   = OP_SETIE;
      word_o = WW'((off - OFF_SETIE) >> 2);
    end else if (off == OFF_SETIENUM) op_o = OP_SETIENUM;
    else if (in_bits(off, OFF_CLRIE)) begin
      op_o   = OP_CLRIE;
      word_o = WW'((off - OFF_CLRIE) >> 2);
    end else if (off == OFF_CLRIENUM) op_o = OP_CLRIENUM;
    else if (off == OFF_NUM_LE)  op_o = OP_NUM_LE;
    else if (off == OFF_NUM_BE)  op_o = OP_NUM_BE;
    else if (off == OFF_GENMSI)  op_o = OP_GENMSI;
    else if (in_arr(off, OFF_TARGET)) begin
      op_o  = OP_TARGET;
      src_o = IW'(((off - OFF_TARGET) >> 2) + 32'd1);
    end
  end

  assign err_o = (off[1:0] != 2'b00) || (size_i != 3'd4) || (op_o == OP_NONE);

endmodule

// File: rtl/irqd_bit_gather.sv
module irqd_bit_gather #(
  parameter int NIRQ   = 41,
  parameter int NWORDS = 2,
  parameter int WW     = 1
) (
  input  logic [NIRQ-1:0] bits_i,
  input  logic [WW-1:0]   word_i,
  output logic [31:0]     word_o
);

  logic [NWORDS*32-1:0] padded;
  logic [31:0]          words [NWORDS];

  // source 0 does not exist
  always_comb begin
    padded = '0;
    padded[NIRQ-1:0] = bits_i & ~NIRQ'(1);
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign words[w] = padded[w*32 +: 32];
  end

  always_comb begin
    word_o = '0;
    for (int w = 0; w < NWORDS; w++)
      if (word_i == WW'(w)) word_o = words[w];
  end

endmodule

// File: rtl/irqd_strobe_gen.sv
module irqd_strobe_gen
  import irqd_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NIRQ    = 41,
  parameter int WW      = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  reg_op_e         op_i,
  input  logic [WW-1:0]   word_i,
  input  logic [31:0]     wdata_i,
  output logic [NIRQ-1:0] set_pend_o,
  output logic [NIRQ-1:0] clr_pend_o,
  output logic [NIRQ-1:0] set_en_o,
  output logic [NIRQ-1:0] clr_en_o
);

  logic [31:0]     num;
  logic [NIRQ-1:0] sp_d, cp_d, se_d, ce_d;
  logic            is_sp_num;

  assign num = (op_i == OP_NUM_BE) ?
               {wdata_i[7:0], wdata_i[15:8], wdata_i[23:16], wdata_i[31:24]} : wdata_i;
  assign is_sp_num = (op_i == OP_SETIPNUM) || (op_i == OP_NUM_LE) || (op_i == OP_NUM_BE);

  assign sp_d[0] = 1'b0;
  assign cp_d[0] = 1'b0;
  assign se_d[0] = 1'b0;
  assign ce_d[0] = 1'b0;

  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_src
    localparam int W = i / 32;
    localparam int B = i % 32;
    logic arr_hit, num_hit;
    assign arr_hit = (word_i == WW'(W)) && wdata_i[B];
    assign num_hit = (num == 32'(i));
    assign sp_d[i] = fire_i && (((op_i == OP_SETIP) && arr_hit) || (is_sp_num && num_hit));
    assign cp_d[i] = fire_i && (((op_i == OP_CLRIP) && arr_hit) || ((op_i == OP_CLRIPNUM) && num_hit));
    assign se_d[i] = fire_i && (((op_i == OP_SETIE) && arr_hit) || ((op_i == OP_SETIENUM) && num_hit));
    assign ce_d[i] = fire_i && (((op_i == OP_CLRIE) && arr_hit) || ((op_i == OP_CLRIENUM) && num_hit));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_pend_o <= '0;
      clr_pend_o <= '0;
      set_en_o   <= '0;
      clr_en_o   <= '0;
    end else begin
      set_pend_o <= sp_d;
      clr_pend_o <= cp_d;
      set_en_o   <= se_d;
      clr_en_o   <= ce_d;
    end
  end

endmodule

// File: rtl/irqd_regdec.sv
module irqd_regdec
  import irqd_pkg::*;
#(
  parameter int          NUM_SRC   = 40,
  parameter int          AW        = 16,
  parameter int          IE_BIT    = 8,
  parameter int          DM_BIT    = 2,
  parameter logic [31:0] RO_MASK   = 32'h8000_0000,
  parameter int          GUEST_LSB = 12,
  parameter int          GUEST_W   = 6,
  localparam int         NIRQ      = NUM_SRC + 1,
  localparam int         IW        = $clog2(NIRQ),
  localparam int         NWORDS    = (NIRQ + 31) / 32,
  localparam int         WW        = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [2:0]      req_size_i,
  input  logic [31:0]     req_wdata_i,
  output logic            rsp_valid_o,
  output logic            rsp_err_o,
  output logic [31:0]     rsp_rdata_o,
  output logic [IW-1:0]   rd_src_o,
  input  logic [31:0]     cfg_rdata_i,
  input  logic [31:0]     tgt_rdata_i,
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] level_i,
  input  logic [NIRQ-1:0] en_i,
  output logic [NIRQ-1:0] set_pend_o,
  output logic [NIRQ-1:0] clr_pend_o,
  output logic [NIRQ-1:0] set_en_o,
  output logic [NIRQ-1:0] clr_en_o,
  output logic            cfg_we_o,
  output logic            tgt_we_o,
  output logic [IW-1:0]   wr_src_o,
  output logic [31:0]     wr_data_o,
  output logic            dom_ie_o,
  output logic            msi_req_o,
  output logic [31:0]     genmsi_o,
  output logic            rescan_o
);

  localparam logic [31:0] GUEST_MASK = ((32'd1 << GUEST_W) - 32'd1) << GUEST_LSB;

  reg_op_e       op;
  logic [IW-1:0] dec_src;
  logic [WW-1:0] dec_word;
  logic          dec_err;
  logic          wr_fire, rd_fire;
  logic [31:0]   pend_word, lvl_word, en_word, rd_mux;
  logic          ie_q, wr_acc_q;
  logic [31:0]   genmsi_q;

  irqd_addr_decode #(
    .AW(AW), .NUM_SRC(NUM_SRC), .NWORDS(NWORDS), .IW(IW), .WW(WW)
  ) u_dec (
    .addr_i(req_addr_i), .size_i(req_size_i),
    .op_o(op), .src_o(dec_src), .word_o(dec_word), .err_o(dec_err)
  );

  irqd_bit_gather #(.NIRQ(NIRQ), .NWORDS(NWORDS), .WW(WW)) u_gat_pend (
    .bits_i(pend_i), .word_i(dec_word), .word_o(pend_word)
  );
  irqd_bit_gather #(.NIRQ(NIRQ), .NWORDS(NWORDS), .WW(WW)) u_gat_lvl (
    .bits_i(level_i), .word_i(dec_word), .word_o(lvl_word)
  );
  irqd_bit_gather #(.NIRQ(NIRQ), .NWORDS(NWORDS), .WW(WW)) u_gat_en (
    .bits_i(en_i), .word_i(dec_word), .word_o(en_word)
  );

  assign wr_fire  = req_valid_i && !dec_err && req_write_i;
  assign rd_fire  = req_valid_i && !dec_err && !req_write_i;
  assign rd_src_o = dec_src;

  irqd_strobe_gen #(.NUM_SRC(NUM_SRC), .NIRQ(NIRQ), .WW(WW)) u_stb (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(wr_fire), .op_i(op),
    .word_i(dec_word), .wdata_i(req_wdata_i),
    .set_pend_o(set_pend_o), .clr_pend_o(clr_pend_o),
    .set_en_o(set_en_o), .clr_en_o(clr_en_o)
  );

  always_comb begin
    unique case (op)
      OP_DOMCFG: rd_mux = RO_MASK | (32'd1 << DM_BIT) | (32'(ie_q) << IE_BIT);
      OP_SRCCFG: rd_mux = cfg_rdata_i;
      OP_SETIP:  rd_mux = pend_word;
      OP_CLRIP:  rd_mux = lvl_word;  // input levels, not pending
      OP_SETIE:  rd_mux = en_word;
      OP_GENMSI: rd_mux = genmsi_q;
      OP_TARGET: rd_mux = tgt_rdata_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
      ie_q        <= 1'b0;
      genmsi_q    <= '0;
      msi_req_o   <= 1'b0;
      cfg_we_o    <= 1'b0;
      tgt_we_o    <= 1'b0;
      wr_src_o    <= '0;
      wr_data_o   <= '0;
      wr_acc_q    <= 1'b0;
      rescan_o    <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && dec_err;
      rsp_rdata_o <= rd_fire ? rd_mux : '0;
      msi_req_o   <= wr_fire && (op == OP_GENMSI);
      cfg_we_o    <= wr_fire && (op == OP_SRCCFG);
      tgt_we_o    <= wr_fire && (op == OP_TARGET);
      wr_acc_q    <= wr_fire;
      rescan_o    <= wr_acc_q;
      if (wr_fire && (op == OP_DOMCFG)) ie_q <= req_wdata_i[IE_BIT];
      if (wr_fire && (op == OP_GENMSI)) genmsi_q <= req_wdata_i & ~GUEST_MASK;
      if (wr_fire && ((op == OP_SRCCFG) || (op == OP_TARGET))) begin
        wr_src_o  <= dec_src;
        wr_data_o <= req_wdata_i;
      end
    end
  end

  assign dom_ie_o = ie_q;
  assign genmsi_o = genmsi_q;

endmodule

// File: rtl/irqd_regdec_chk.sv
module irqd_regdec_chk #(
  parameter int          NIRQ    = 41,
  parameter int          AW      = 16,
  parameter int          DM_BIT  = 2,
  parameter logic [31:0] RO_MASK = 32'h8000_0000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_write_i,
  input logic [AW-1:0]   req_addr_i,
  input logic [2:0]      req_size_i,
  input logic            rsp_valid_o,
  input logic            rsp_err_o,
  input logic [31:0]     rsp_rdata_o,
  input logic [NIRQ-1:0] set_pend_o,
  input logic [NIRQ-1:0] clr_pend_o,
  input logic [NIRQ-1:0] set_en_o,
  input logic [NIRQ-1:0] clr_en_o,
  input logic            cfg_we_o,
  input logic            tgt_we_o,
  input logic            msi_req_o,
  input logic            rescan_o
);

  p_rsp_follows_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_misalign_err_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[1:0] != 2'b00) |=> rsp_err_o);

  p_size_err_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i != 3'd4) |=> rsp_err_o);

  p_err_silent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (set_pend_o == '0 && clr_pend_o == '0 && set_en_o == '0 &&
                   clr_en_o == '0 && !cfg_we_o && !tgt_we_o && !msi_req_o));

  p_rescan_after_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_err_o && $past(req_write_i)) |=> rescan_o);

  p_rescan_cause_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rescan_o) |-> $past(rsp_valid_o && !rsp_err_o));

  p_domcfg_ro_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i == '0 && req_size_i == 3'd4) |=>
      ((rsp_rdata_o & RO_MASK) == RO_MASK) && rsp_rdata_o[DM_BIT]);

  p_wr_rdata_zero_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> (rsp_rdata_o == '0));

endmodule

bind irqd_regdec irqd_regdec_chk #(
  .NIRQ(NIRQ), .AW(AW), .DM_BIT(DM_BIT), .RO_MASK(RO_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
  .req_addr_i(req_addr_i), .req_size_i(req_size_i), .rsp_valid_o(rsp_valid_o),
  .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o), .set_pend_o(set_pend_o),
  .clr_pend_o(clr_pend_o), .set_en_o(set_en_o), .clr_en_o(clr_en_o),
  .cfg_we_o(cfg_we_o), .tgt_we_o(tgt_we_o), .msi_req_o(msi_req_o), .rescan_o(rescan_o)
);

// File: tb/irqd_regdec_tb.sv
module irqd_regdec_tb;

  localparam int NUM_SRC = 40;
  localparam int NIRQ    = NUM_SRC + 1;
  localparam int IW      = 6;
  localparam int NV      = 29;

  localparam logic [NIRQ-1:0] PEND = 41'h155_1234_5679;
  localparam logic [NIRQ-1:0] LVL  = 41'h0F0_0000_FFFF;
  localparam logic [NIRQ-1:0] EN   = 41'h1AA_8000_0001;

  // {err, offset, expected read data}
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 16'h0000, 32'h8000_0004},
    {1'b0, 16'h0004, 32'hC0F0_0001}, {1'b0, 16'h00A0, 32'hC0F0_0028}, {1'b1, 16'h00A4, 32'h0},
    {1'b0, 16'h3004, 32'h7700_0001}, {1'b0, 16'h30A0, 32'h7700_0028}, {1'b1, 16'h30A4, 32'h0},
    {1'b0, 16'h1C00, 32'h1234_5678}, {1'b0, 16'h1C04, 32'h0000_0155}, {1'b1, 16'h1C08, 32'h0},
    {1'b0, 16'h1D00, 32'h0000_FFFE}, {1'b0, 16'h1D04, 32'h0000_00F0},
    {1'b0, 16'h1E00, 32'h8000_0000}, {1'b0, 16'h1E04, 32'h0000_01AA}, {1'b1, 16'h1E08, 32'h0},
    {1'b0, 16'h1F00, 32'h0}, {1'b0, 16'h1F04, 32'h0},
    {1'b0, 16'h1CDC, 32'h0}, {1'b0, 16'h1DDC, 32'h0}, {1'b0, 16'h1EDC, 32'h0},
    {1'b0, 16'h1FDC, 32'h0}, {1'b0, 16'h2000, 32'h0}, {1'b0, 16'h2004, 32'h0},
    {1'b0, 16'h3000, 32'h0},
    {1'b1, 16'h0800, 32'h0}, {1'b1, 16'h2008, 32'h0}, {1'b1, 16'h1CE0, 32'h0},
    {1'b1, 16'h3FFC, 32'h0}, {1'b1, 16'h0002, 32'h0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [15:0]     req_addr = '0;
  logic [2:0]      req_size = 3'd4;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid, rsp_err;
  logic [31:0]     rsp_rdata, cfg_rdata, tgt_rdata, wr_data, genmsi;
  logic [IW-1:0]   rd_src, wr_src;
  logic [NIRQ-1:0] sp, cp, se, ce;
  logic            cfg_we, tgt_we, dom_ie, msi_req, rescan;

  int n_chk = 0;
  int n_bad = 0;

  logic            c_valid, c_err, c_cfg, c_tgt, c_msi, c_rescan;
  logic [31:0]     c_rd, c_wd, c_gen;
  logic [IW-1:0]   c_src;
  logic [NIRQ-1:0] c_sp, c_cp, c_se, c_ce;

  always #5 clk = ~clk;

  assign cfg_rdata = 32'hC0F0_0000 | 32'(rd_src);
  assign tgt_rdata = 32'h7700_0000 | 32'(rd_src);

  irqd_regdec #(.NUM_SRC(NUM_SRC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .rd_src_o(rd_src), .cfg_rdata_i(cfg_rdata), .tgt_rdata_i(tgt_rdata),
    .pend_i(PEND), .level_i(LVL), .en_i(EN),
    .set_pend_o(sp), .clr_pend_o(cp), .set_en_o(se), .clr_en_o(ce),
    .cfg_we_o(cfg_we), .tgt_we_o(tgt_we), .wr_src_o(wr_src), .wr_data_o(wr_data),
    .dom_ie_o(dom_ie), .msi_req_o(msi_req), .genmsi_o(genmsi), .rescan_o(rescan)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic capture();
    c_valid = rsp_valid; c_err = rsp_err; c_rd = rsp_rdata;
    c_sp = sp; c_cp = cp; c_se = se; c_ce = ce;
    c_cfg = cfg_we; c_tgt = tgt_we; c_src = wr_src; c_wd = wr_data;
    c_msi = msi_req; c_gen = genmsi; c_rescan = rescan;
  endtask

  task automatic issue(input logic wr, input logic [15:0] a, input logic [31:0] d,
                       input logic [2:0] sz);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
    @(posedge clk);
    #1;
    capture();
    req_valid = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    capture();
  endtask

  function automatic logic [63:0] stb_all();
    return 64'(c_sp | c_cp | c_se | c_ce);
  endfunction

  initial begin
    #200_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("reset R13 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("reset R12 rescan", 64'(rescan), 64'd0);
    chk("reset R3 dom_ie", 64'(dom_ie), 64'd0);
    chk("reset R11 genmsi", 64'(genmsi), 64'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      issue(1'b0, VEC[k][47:32], 32'h0, 3'd4);
      chk($sformatf("table[%0d] R2 R3 R4 R6 R7 R10 R11 off=%h", k, VEC[k][47:32]),
          {31'b0, c_err, c_rd}, {31'b0, VEC[k][48], VEC[k][31:0]});
    end

    // R1 bad size and misalignment
    issue(1'b0, 16'h0000, 32'h0, 3'd2);
    chk("R1 read size 2 err", 64'(c_err), 64'd1);
    issue(1'b1, 16'h0000, 32'h0000_0100, 3'd2);
    chk("R1 write size 2 err", 64'(c_err), 64'd1);
    tick();
    chk("R1 size err no rescan", 64'(c_rescan), 64'd0);
    chk("R1 size err keeps ie", 64'(dom_ie), 64'd0);
    issue(1'b1, 16'h1C01, 32'hFFFF_FFFF, 3'd4);
    chk("R1 misaligned err", 64'(c_err), 64'd1);
    chk("R1 misaligned no strobe", stb_all(), 64'd0);
    tick();
    chk("R1 misaligned no rescan", 64'(c_rescan), 64'd0);

    // R3 domain enable
    issue(1'b1, 16'h0000, 32'hFFFF_FFFF, 3'd4);
    chk("R13 write rdata zero", 64'(c_rd), 64'd0);
    chk("R13 write rsp_valid", 64'(c_valid), 64'd1);
    chk("R3 ie set", 64'(dom_ie), 64'd1);
    tick();
    chk("R12 rescan after domcfg write", 64'(c_rescan), 64'd1);
    issue(1'b0, 16'h0000, 32'h0, 3'd4);
    chk("R3 domcfg readback", 64'(c_rd), 64'h8000_0104);
    tick();
    chk("R12 no rescan after read", 64'(c_rescan), 64'd0);

    // R5 bit arrays
    issue(1'b1, 16'h1C00, 32'h0000_0013, 3'd4);
    chk("R5 setip word0 skips source 0", 64'(c_sp), 64'h12);
    chk("R5 setip only set-pending", 64'(c_cp | c_se | c_ce), 64'd0);
    tick();
    chk("R12 rescan pulse", 64'(c_rescan), 64'd1);
    chk("R5 strobe one cycle", stb_all(), 64'd0);
    tick();
    chk("R12 rescan one cycle", 64'(c_rescan), 64'd0);
    issue(1'b1, 16'h1C04, 32'hFFFF_FFFF, 3'd4);
    chk("R5 R10 setip word1", 64'(c_sp), 64'h1FF_0000_0000);
    issue(1'b1, 16'h1C00, 32'h0, 3'd4);
    chk("R5 zero bits no effect", stb_all(), 64'd0);
    issue(1'b1, 16'h1D00, 32'h0000_0004, 3'd4);
    chk("R5 clrip word0", 64'(c_cp), 64'h4);
    issue(1'b1, 16'h1E04, 32'h0000_0001, 3'd4);
    chk("R5 setie word1", 64'(c_se), 64'h1_0000_0000);
    issue(1'b1, 16'h1F00, 32'h8000_0000, 3'd4);
    chk("R5 clrie word0", 64'(c_ce), 64'h0_8000_0000);

    // R8 R9 number registers
    issue(1'b1, 16'h1CDC, 32'd5, 3'd4);
    chk("R8 setipnum 5", 64'(c_sp), 64'h20);
    issue(1'b1, 16'h1CDC, 32'd0, 3'd4);
    chk("R8 setipnum 0 no strobe", stb_all(), 64'd0);
    chk("R8 setipnum 0 no err", 64'(c_err), 64'd0);
    tick();
    chk("R8 R12 setipnum 0 rescan", 64'(c_rescan), 64'd1);
    issue(1'b1, 16'h1CDC, 32'd41, 3'd4);
    chk("R8 setipnum 41 no strobe", stb_all(), 64'd0);
    issue(1'b1, 16'h1DDC, 32'd40, 3'd4);
    chk("R8 clripnum 40", 64'(c_cp), 64'h100_0000_0000);
    issue(1'b1, 16'h1EDC, 32'd7, 3'd4);
    chk("R8 setienum 7", 64'(c_se), 64'h80);
    issue(1'b1, 16'h1FDC, 32'd3, 3'd4);
    chk("R8 clrienum 3", 64'(c_ce), 64'h8);
    issue(1'b1, 16'h2000, 32'd9, 3'd4);
    chk("R8 le setipnum 9", 64'(c_sp), 64'h200);
    issue(1'b1, 16'h2004, 32'h0C00_0000, 3'd4);
    chk("R9 be swapped 12", 64'(c_sp), 64'h1000);
    issue(1'b1, 16'h2004, 32'h0000_000C, 3'd4);
    chk("R9 be unswapped out of range", stb_all(), 64'd0);

    // R4 config and target writes
    issue(1'b1, 16'h0008, 32'h0000_0ABC, 3'd4);
    chk("R4 cfg_we", {62'd0, c_cfg, c_tgt}, 64'd2);
    chk("R4 cfg src", 64'(c_src), 64'd2);
    chk("R4 cfg data", 64'(c_wd), 64'h0ABC);
    issue(1'b1, 16'h30A0, 32'h0000_0055, 3'd4);
    chk("R4 tgt_we", {62'd0, c_cfg, c_tgt}, 64'd1);
    chk("R4 tgt src", 64'(c_src), 64'd40);

    // R11 generate message
    issue(1'b1, 16'h3000, 32'hFFFF_FFFF, 3'd4);
    chk("R11 msi_req", 64'(c_msi), 64'd1);
    chk("R11 genmsi guest cleared", 64'(c_gen), 64'hFFFC_0FFF);
    issue(1'b0, 16'h3000, 32'h0, 3'd4);
    chk("R11 genmsi read", 64'(c_rd), 64'hFFFC_0FFF);
    chk("R11 msi_req one cycle", 64'(c_msi), 64'd0);

    // R12 rescan meets next write's strobes
    issue(1'b1, 16'h1CDC, 32'd5, 3'd4);
    issue(1'b1, 16'h1CDC, 32'd6, 3'd4);
    chk("R12 back-to-back strobe", 64'(c_sp), 64'h40);
    chk("R12 back-to-back rescan", 64'(c_rescan), 64'd1);
    issue(1'b1, 16'h1CDE, 32'd7, 3'd4);
    chk("R1 R12 err after write no strobe", stb_all(), 64'd0);
    chk("R1 R12 err after write rescan", 64'(c_rescan), 64'd1);
    tick();
    chk("R1 R12 err no own rescan", 64'(c_rescan), 64'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule